// File: doc/BRIEF.md
# Complementary PWM Dead-Time Inserter

This block turns one reference PWM waveform per channel into a pair of non-overlapping drive signals: a main output that follows the reference and a complementary output that follows its inverse. Whenever the reference changes level, the output that must switch off does so at once. The output that must switch on waits for a programmable dead time first. The two outputs of a pair are therefore never active together. It sits between a PWM generator and a half-bridge gate driver.

The dead time comes from an 8-bit code that uses a piecewise, non-linear format. Small values are exact tick counts. Larger values use coarser steps, so the range reaches 1008 ticks. One tick is one cycle of `clk`, which is the dead-time clock. Each output has its own polarity, enable and idle level. A global output-enable input overrides the pair and drives the idle levels at once. The code register can be read back.

Top module: `dtins_top`

## Requirements
- R1: A code with bit 7 clear gives a dead time of bits 6:0 ticks (0 to 127).
- R2: A code with bits 7:6 equal to 10 gives a dead time of (bits 5:0 + 64) × 2 ticks. For example, 0x85 gives 138 and 0xBF gives 254.
- R3: A code with bits 7:5 equal to 110 gives a dead time of (bits 4:0 + 32) × 8 ticks. For example, 0xC3 gives 280.
- R4: A code with bits 7:5 equal to 111 gives a dead time of (bits 4:0 + 32) × 16 ticks. For example, 0xE0 gives 512 and 0xFF gives 1008, which is the maximum.
- R5: `cfgCode` resets to 0x00. On the cycle after a `cfgWr` strobe it returns exactly the byte that was written.
- R6: Let a rising reference be sampled at clock edge k, and let D be the decoded dead time in force before edge k. The complementary output is inactive from edge k. The main output is active from edge k+D; with D = 0 that is edge k itself.
- R7: A falling reference works the same way with the roles swapped. The main output is inactive from edge k and the complementary output is active from edge k+D.
- R8: If a reference level lasts D cycles or fewer, the output that would turn on during that level stays inactive for the whole of it.
- R9: The pin level is the logical level XOR the polarity bit of that output (1 = active low).
- R10: When an output's enable is 0, that output drives its inactive level, which is the logical level 0 passed through polarity. The main and complementary enables are independent.
- R11: When `outEnable` is 0, each pin drives its idle bit (0 = reset, 1 = set) passed through polarity, in the same cycle and with no dead-time delay.
- R12: While `outEnable` is 1, the main and complementary outputs of a channel are never logically active at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dead-time clock; one cycle is one tick |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWr | input | 1 | Write strobe for the dead-time code |
| cfgData | input | 8 | Dead-time code to write |
| cfgCode | output | 8 | Readback of the stored dead-time code |
| outEnable | input | 1 | Global output enable; 0 forces the idle levels |
| refPwm | input | NUM_CH | Reference PWM, one bit per channel |
| mainEn | input | NUM_CH | Main output enable per channel |
| compEn | input | NUM_CH | Complementary output enable per channel |
| mainPolLow | input | NUM_CH | Main output active low when 1 |
| compPolLow | input | NUM_CH | Complementary output active low when 1 |
| mainIdle | input | NUM_CH | Main idle logical level |
| compIdle | input | NUM_CH | Complementary idle logical level |
| mainOut | output | NUM_CH | Main output pins |
| compOut | output | NUM_CH | Complementary output pins |

## Verification
Codes are chosen in every one of the four decode ranges, with boundary values at both ends of the ranges. This separates a wrong range select from a wrong offset or a wrong step. For each code, the bench measures the turn-on delay of the main output after a rising edge and of the complementary output after a falling edge. This distinguishes a delay that is shared between the two edges from one that applies to one edge only. Reference pulses shorter than, equal to and longer than the dead time expose off-by-one errors in the counter. A second channel runs an irregular toggle pattern throughout, which exposes cross-channel coupling. Separate phases for polarity, per-output enable and global idle forcing show that each control acts on its own output only.

// File: rtl/dtins_pkg.sv
package dtins_pkg;
  localparam int DT_CODE_W = 8;
  localparam int DT_TICK_W = 10;

  // per-channel strobes from control to datapath
  typedef struct packed {
    logic chg;     // reference changed level this cycle
    logic lvlNew;  // level the reference now has
  } chStrobeT;

  // piecewise dead-time code to tick count
  function automatic logic [DT_TICK_W-1:0] decodeDeadTime(input logic [DT_CODE_W-1:0] c);
    logic [DT_TICK_W-1:0] t;
    if (!c[7])
      t = {3'b000, c[6:0]};
    else if (!c[6])
      t = ({4'b0000, c[5:0]} + 10'd64) << 1;
    else if (!c[5])
      t = ({5'b00000, c[4:0]} + 10'd32) << 3;
    else
      t = ({5'b00000, c[4:0]} + 10'd32) << 4;
    return t;
  endfunction
endpackage

// File: rtl/dtins_ctrl.sv
module dtins_ctrl
  import dtins_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter logic [DT_CODE_W-1:0] CODE_RST = '0
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     cfgWr,
  input  logic [DT_CODE_W-1:0]     cfgData,
  input  logic [NUM_CH-1:0]        refPwm,
  output logic [DT_CODE_W-1:0]     codeQ,
  output logic [DT_TICK_W-1:0]     dtTicks,
  output chStrobeT [NUM_CH-1:0]    strobes
);
  localparam logic [DT_TICK_W-1:0] MAX_TICKS = 10'd1008;

  logic [NUM_CH-1:0] refPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeQ   <= CODE_RST;
      refPrev <= '0;
    end else begin
      if (cfgWr) codeQ <= cfgData;
      refPrev <= refPwm;
    end
  end

  assign dtTicks = decodeDeadTime(codeQ);

  for (genvar i = 0; i < NUM_CH; i++) begin : gStb
    assign strobes[i].chg    = refPwm[i] ^ refPrev[i];
    assign strobes[i].lvlNew = refPwm[i];
  end

  AST_CODE_READBACK: assert property (@(posedge clk) disable iff (!rstN)
    $past(cfgWr) |-> codeQ == $past(cfgData)); // R5
  AST_TICKS_MAX: assert property (@(posedge clk) disable iff (!rstN)
    dtTicks <= MAX_TICKS); // R4
endmodule

// File: rtl/dtins_datapath.sv
module dtins_datapath
  import dtins_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  chStrobeT [NUM_CH-1:0]    strobes,
  input  logic [DT_TICK_W-1:0]     dtTicks,
  input  logic                     outEnable,
  input  logic [NUM_CH-1:0]        mainEn,
  input  logic [NUM_CH-1:0]        compEn,
  input  logic [NUM_CH-1:0]        mainPolLow,
  input  logic [NUM_CH-1:0]        compPolLow,
  input  logic [NUM_CH-1:0]        mainIdle,
  input  logic [NUM_CH-1:0]        compIdle,
  output logic [NUM_CH-1:0]        mainOut,
  output logic [NUM_CH-1:0]        compOut
);
  localparam logic [DT_TICK_W-1:0] MAX_TICKS = 10'd1008;

  logic [NUM_CH-1:0] lvl;
  logic [NUM_CH-1:0] mainAct;
  logic [NUM_CH-1:0] compAct;
  logic [DT_TICK_W-1:0] cnt [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : gCh
    logic mainLog;
    logic compLog;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        lvl[i] <= 1'b0;
        cnt[i] <= '0;
      end else if (strobes[i].chg) begin
        lvl[i] <= strobes[i].lvlNew;
        cnt[i] <= dtTicks;
      end else if (cnt[i] != '0) begin
        cnt[i] <= cnt[i] - 1'b1;
      end
    end

    assign mainAct[i] = lvl[i] & (cnt[i] == '0);
    assign compAct[i] = ~lvl[i] & (cnt[i] == '0);

    assign mainLog = outEnable ? (mainEn[i] & mainAct[i]) : mainIdle[i];
    assign compLog = outEnable ? (compEn[i] & compAct[i]) : compIdle[i];
    assign mainOut[i] = mainLog ^ mainPolLow[i];
    assign compOut[i] = compLog ^ compPolLow[i];

    AST_OFF_IMMEDIATE: assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(strobes[i].chg && strobes[i].lvlNew)) |-> !compAct[i]); // R6
    AST_DEAD_GAP: assert property (@(posedge clk) disable iff (!rstN)
      (mainAct[i] && $past(compAct[i])) |-> $past(dtTicks) == '0); // R6
    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
      cnt[i] <= MAX_TICKS); // R4
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rstN)
      outEnable |-> !((mainOut[i] ^ mainPolLow[i]) && (compOut[i] ^ compPolLow[i]))); // R12
  end
endmodule

// File: rtl/dtins_top.sv
module dtins_top
  import dtins_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter logic [DT_CODE_W-1:0] CODE_RST = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWr,
  input  logic [DT_CODE_W-1:0] cfgData,
  output logic [DT_CODE_W-1:0] cfgCode,
  input  logic                 outEnable,
  input  logic [NUM_CH-1:0]    refPwm,
  input  logic [NUM_CH-1:0]    mainEn,
  input  logic [NUM_CH-1:0]    compEn,
  input  logic [NUM_CH-1:0]    mainPolLow,
  input  logic [NUM_CH-1:0]    compPolLow,
  input  logic [NUM_CH-1:0]    mainIdle,
  input  logic [NUM_CH-1:0]    compIdle,
  output logic [NUM_CH-1:0]    mainOut,
  output logic [NUM_CH-1:0]    compOut
);
  chStrobeT [NUM_CH-1:0] strobes;
  logic [DT_TICK_W-1:0]  dtTicks;

  dtins_ctrl #(.NUM_CH(NUM_CH), .CODE_RST(CODE_RST)) i_ctrl (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData),
    .refPwm(refPwm), .codeQ(cfgCode), .dtTicks(dtTicks), .strobes(strobes)
  );

  dtins_datapath #(.NUM_CH(NUM_CH)) i_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .dtTicks(dtTicks),
    .outEnable(outEnable), .mainEn(mainEn), .compEn(compEn),
    .mainPolLow(mainPolLow), .compPolLow(compPolLow),
    .mainIdle(mainIdle), .compIdle(compIdle),
    .mainOut(mainOut), .compOut(compOut)
  );
endmodule

// File: tb/test_dtins_top.sv
module test_dtins_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWr = 1'b0;
  logic [7:0] cfgData = '0;
  logic [7:0] cfgCode;
  logic outEnable = 1'b1;
  logic ref0 = 1'b0, ref1 = 1'b0;
  logic [1:0] refPwm;
  logic [1:0] mainEn = 2'b11, compEn = 2'b11;
  logic [1:0] mainPolLow = '0, compPolLow = '0;
  logic [1:0] mainIdle = '0, compIdle = '0;
  logic [1:0] mainOut, compOut;

  int checks = 0, errors = 0;
  bit finished = 0;
  string curReq = "R6";

  assign refPwm = {ref1, ref0};
  always #5 clk = ~clk;

  dtins_top i_dtins_top (
    .clk(clk), .rstN(rstN), .cfgWr(cfgWr), .cfgData(cfgData), .cfgCode(cfgCode),
    .outEnable(outEnable), .refPwm(refPwm), .mainEn(mainEn), .compEn(compEn),
    .mainPolLow(mainPolLow), .compPolLow(compPolLow),
    .mainIdle(mainIdle), .compIdle(compIdle), .mainOut(mainOut), .compOut(compOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int refDecode(input int c);
    if (c < 128) return c;
    if (c < 192) return 2 * (c - 64);
    if (c < 224) return 8 * (c - 160);
    return 16 * (c - 192);
  endfunction

  // behavioural model: time since last reference change
  int cyc, codeM;
  int lastChg [2];
  int dtAt [2];
  bit lvlM [2];

  always @(posedge clk) begin
    if (!rstN) begin
      cyc = 0; codeM = 0;
      for (int c = 0; c < 2; c++) begin lvlM[c] = 0; lastChg[c] = -100000; dtAt[c] = 0; end
    end else begin
      cyc++;
      for (int c = 0; c < 2; c++)
        if (refPwm[c] != lvlM[c]) begin
          lvlM[c] = refPwm[c]; lastChg[c] = cyc; dtAt[c] = refDecode(codeM);
        end
      if (cfgWr) codeM = int'(cfgData);
    end
  end

  always @(negedge clk) begin
    if (rstN && !finished) begin
      for (int c = 0; c < 2; c++) begin
        bit ready, mL, cL, mP, cP;
        ready = (cyc - lastChg[c]) >= dtAt[c];
        mL = outEnable ? (mainEn[c] & lvlM[c] & ready) : mainIdle[c];
        cL = outEnable ? (compEn[c] & !lvlM[c] & ready) : compIdle[c];
        mP = mL ^ mainPolLow[c];
        cP = cL ^ compPolLow[c];
        chk(mainOut[c] == mP, {curReq, " main"}, int'(mainOut[c]), int'(mP));
        chk(compOut[c] == cP, {curReq, " comp"}, int'(compOut[c]), int'(cP));
        if (outEnable)
          chk(!((mainOut[c] ^ mainPolLow[c]) && (compOut[c] ^ compPolLow[c])),
              "R12 overlap", 1, 0);
      end
      chk(int'(cfgCode) == codeM, "R5 readback", int'(cfgCode), codeM);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic writeCode(input logic [7:0] c);
    cfgWr = 1'b1; cfgData = c;
    step(1);
    cfgWr = 1'b0;
    chk(cfgCode == c, "R5 write", int'(cfgCode), int'(c));
  endtask

  // turn-on delay of main (rising) or comp (falling) on channel 0
  task automatic measureEdge(input bit rising, input int expT, input string req);
    int n;
    ref0 = !rising;
    step(expT + 4);
    ref0 = rising;
    n = 0;
    @(negedge clk);
    while (n < 1100 && (rising ? mainOut[0] : compOut[0]) != 1'b1) begin
      n++;
      @(negedge clk);
    end
    #1;
    chk(n == expT, req, n, expT);
  endtask

  task automatic pulseSilent(input bit high, input int len, input string req);
    bit seen;
    seen = 0;
    ref0 = high;
    for (int k = 0; k < len; k++) begin
      @(negedge clk);
      if ((high ? mainOut[0] : compOut[0]) == 1'b1) seen = 1;
    end
    #1;
    ref0 = !high;
    chk(!seen, req, int'(seen), 0);
  endtask

  // second channel: irregular toggles
  initial begin
    wait (rstN);
    forever begin
      step(7);  ref1 = ~ref1;
      step(13); ref1 = ~ref1;
      step(2);  ref1 = ~ref1;
      step(31); ref1 = ~ref1;
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    step(4);
    rstN = 1'b1;
    step(1);
    chk(cfgCode == 8'h00, "R5 reset value", int'(cfgCode), 0);
    chk(compOut[0] == 1'b1 && mainOut[0] == 1'b0, "R7 reset state", int'(compOut[0]), 1);

    curReq = "R1"; writeCode(8'h00);
    measureEdge(1, 0, "R1 code 0x00 rise"); measureEdge(0, 0, "R1 code 0x00 fall");
    writeCode(8'h05);
    measureEdge(1, 5, "R1 R6 code 0x05 rise"); measureEdge(0, 5, "R1 R7 code 0x05 fall");
    writeCode(8'h7F);
    measureEdge(1, 127, "R1 code 0x7F rise");
    curReq = "R2"; writeCode(8'h85);
    measureEdge(1, 138, "R2 code 0x85 rise"); measureEdge(0, 138, "R2 code 0x85 fall");
    writeCode(8'hBF);
    measureEdge(1, 254, "R2 code 0xBF rise");
    curReq = "R3"; writeCode(8'hC3);
    measureEdge(1, 280, "R3 code 0xC3 rise"); measureEdge(0, 280, "R3 code 0xC3 fall");
    curReq = "R4"; writeCode(8'hE0);
    measureEdge(0, 512, "R4 code 0xE0 fall");
    writeCode(8'hFF);
    measureEdge(1, 1008, "R4 code 0xFF rise");

    curReq = "R8"; writeCode(8'h05);
    step(1100); ref0 = 1'b0; step(10);
    pulseSilent(1, 3, "R8 short high pulse"); step(10);
    pulseSilent(1, 5, "R8 high pulse equal to dead time"); step(10);
    ref0 = 1'b1; step(10);
    pulseSilent(0, 4, "R8 short low pulse"); step(10);
    ref0 = 1'b1; step(6); ref0 = 1'b0; step(10);

    curReq = "R9";
    mainPolLow = 2'b11; compPolLow = 2'b11;
    ref0 = 1'b1; step(10);
    chk(mainOut[0] == 1'b0 && compOut[0] == 1'b1, "R9 active low", int'(mainOut[0]), 0);
    ref0 = 1'b0; step(10);
    mainPolLow = 2'b00; compPolLow = 2'b01; step(20);

    curReq = "R10";
    mainEn = 2'b10; compPolLow = 2'b00;
    ref0 = 1'b1; step(10);
    chk(mainOut[0] == 1'b0, "R10 main disabled", int'(mainOut[0]), 0);
    ref0 = 1'b0; step(10);
    chk(compOut[0] == 1'b1, "R10 comp still enabled", int'(compOut[0]), 1);
    mainEn = 2'b11; compEn = 2'b10; mainPolLow = 2'b01; step(10);
    chk(compOut[0] == 1'b0 && mainOut[0] == 1'b1, "R10 comp disabled", int'(compOut[0]), 0);
    compEn = 2'b11; mainPolLow = 2'b00; step(20);

    curReq = "R11";
    ref0 = 1'b1; step(10);
    mainIdle = 2'b00; compIdle = 2'b11; outEnable = 1'b0;
    #1;
    chk(mainOut[0] == 1'b0 && compOut[0] == 1'b1, "R11 idle forced", int'(compOut[0]), 1);
    compPolLow = 2'b01; #1;
    chk(compOut[0] == 1'b0, "R11 idle through polarity", int'(compOut[0]), 0);
    step(20);
    outEnable = 1'b1; compPolLow = 2'b00; step(20);

    curReq = "R12"; writeCode(8'h02);
    for (int k = 0; k < 40; k++) begin ref0 = ~ref0; step(1 + (k % 5)); end
    step(20);
    finish();
  end
endmodule